// File: doc/BRIEF.md
# Real-Time Clock Time-Base, Counter and Alarm Core

This core keeps elapsed time in a slow real-time clock domain. A reloadable down-counting prescaler turns the real-time source clock into a time-base tick, one per second when the reload value matches the source frequency. Each tick advances a 32-bit up-counter. A 32-bit alarm value is compared against the counter as it advances.

Three sticky event flags record a tick (second), an alarm match and a counter wrap (overflow). A per-flag enable mask selects which of them drive the single interrupt output. All configuration arrives from a faster bus clock as single writes. Each write carries a select code and a data word. A write is held in the bus domain and announced to the real-time domain by a toggle that passes through a synchronizer. It is acknowledged back by a second toggle. While a write is in flight, a busy output is high.

The real-time clock must run at least four times slower than the bus clock.

Top module: `rtc_core`

## Requirements
- R1: After reset the counter reads 0, all three flags are 0, the interrupt output is 0, busy is 0, and the prescaler reload value is the RST_RELOAD parameter.
- R2: With a reload value R held in the prescaler, the tick occurs once every R+1 real-time clock cycles, and every cycle when R is 0. The reload value is taken from write data bits [PRE_W-1:0] of a select-1 write. Higher data bits have no effect.
- R3: The counter increases by exactly one on each tick and holds between ticks. A select-0 write loads the counter with the write data.
- R4: Applying a counter load (select 0) or a reload write (select 1) restarts the prescaler from the current reload value. The first tick then follows R+1 cycles after the load.
- R5: Flag bit 0 (second) is set on every tick.
- R6: Flag bit 1 (alarm) is set on the tick where the counter becomes equal to the alarm value. The alarm value is written with select 2.
- R7: Flag bit 2 (overflow) is set on the tick where the counter wraps from all ones to 0.
- R8: Flags stay set until cleared. A select-3 write clears each flag whose bit is 1 in data[2:0] and leaves the others unchanged.
- R9: The interrupt output is high exactly when some flag is set and its enable bit is set. The enable mask is written with select 4 from data[2:0], using the same bit order as the flags.
- R10: An accepted write raises busy from the next bus clock cycle until the write has taken effect in the real-time domain. A write presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the write side |
| rtc_clk | input | 1 | Real-time source clock, at least 4x slower than bus_clk |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each domain |
| wr_en | input | 1 | Write strobe, one bus clock cycle |
| wr_sel | input | 3 | Write target: 0 counter, 1 reload, 2 alarm, 3 flag clear, 4 enable mask |
| wr_data | input | CNT_W | Write data |
| wr_busy | output | 1 | A write is in flight across the domains |
| rtc_tick | output | 1 | Time-base tick, one real-time clock cycle wide |
| rtc_count | output | CNT_W | Elapsed-time counter |
| rtc_flags | output | 3 | Sticky flags: bit 0 second, bit 1 alarm, bit 2 overflow |
| rtc_irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the core with the full 20-bit prescaler and 32-bit counter, but sets RST_RELOAD to 3 so that ticks arrive within a few real-time cycles of reset. Reload values of 0, 1, 3 and 200 place fast, slow and every-cycle ticking in the same run. The slow setting of 200 gives a quiet window in which flags can be cleared and writes can be overlapped without an interfering tick. Loading the counter near all ones brings the wrap and the overflow flag within four ticks. A reload write with bit 20 set shows that only the 20-bit field is kept.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_RELOAD = 3'd1,
    SEL_ALARM  = 3'd2,
    SEL_CLEAR  = 3'd3,
    SEL_ENABLE = 3'd4
  } wr_sel_e;

  localparam int FLAG_SEC  = 0;
  localparam int FLAG_ALM  = 1;
  localparam int FLAG_OVF  = 2;
  localparam int NUM_FLAGS = 3;
  localparam int SEL_W     = 3;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign srst_n = sr_q[STAGES-1];
endmodule

// File: rtl/rtc_wr_cdc.sv
module rtc_wr_cdc #(
  parameter int DW = 32,
  parameter int SW = 3
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          apply,
  output logic [SW-1:0] ap_sel,
  output logic [DW-1:0] ap_data
);
  // bus side: holding registers and request toggle
  logic          req_q, req_d;
  logic [SW-1:0] sel_q, sel_d;
  logic [DW-1:0] data_q, data_d;
  logic [1:0]    ack_s;
  logic          accept;
  // real-time side: request synchronizer, last stage doubles as ack toggle
  logic [2:0]    req_s;
  logic          ack_q;

  assign accept = wr_en & ~busy;
  assign busy   = req_q ^ ack_s[1];

  always_comb begin
    req_d  = req_q ^ accept;
    sel_d  = accept ? wr_sel  : sel_q;
    data_d = accept ? wr_data : data_q;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q  <= 1'b0;
      sel_q  <= '0;
      data_q <= '0;
      ack_s  <= '0;
    end else begin
      req_q  <= req_d;
      sel_q  <= sel_d;
      data_q <= data_d;
      ack_s  <= {ack_s[0], ack_q};
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) req_s <= '0;
    else         req_s <= {req_s[1:0], req_q};
  end

  assign ack_q   = req_s[2];
  assign apply   = req_s[2] ^ req_s[1];
  assign ap_sel  = sel_q;
  assign ap_data = data_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PW         = 20,
  parameter int RST_RELOAD = 32767
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_we,
  input  logic [PW-1:0] reload_val,
  input  logic          restart,
  output logic          tick
);
  localparam logic [PW-1:0] ONE   = PW'(1);
  localparam logic [PW-1:0] RST_V = PW'(RST_RELOAD);

  logic [PW-1:0] reload_q, reload_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick    = at_zero & ~restart;

  always_comb begin
    reload_d = reload_we ? reload_val : reload_q;
    if (restart)      cnt_d = reload_d;
    else if (at_zero) cnt_d = reload_q;
    else              cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RST_V;
      cnt_q    <= RST_V;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_core_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load_we,
  input  logic                 alarm_we,
  input  logic                 clr_we,
  input  logic                 en_we,
  input  logic [CW-1:0]        wdata,
  output logic [CW-1:0]        count,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]        count_q, count_d, inc;
  logic [CW-1:0]        alarm_q, alarm_d;
  logic [NUM_FLAGS-1:0] flag_q, flag_d, set_v;
  logic [NUM_FLAGS-1:0] en_q, en_d;

  always_comb begin
    inc            = count_q + ONE;
    count_d        = load_we ? wdata : (tick ? inc : count_q);
    alarm_d        = alarm_we ? wdata : alarm_q;
    en_d           = en_we ? wdata[NUM_FLAGS-1:0] : en_q;
    set_v          = '0;
    set_v[FLAG_SEC] = tick;
    set_v[FLAG_ALM] = tick & (inc == alarm_q);
    set_v[FLAG_OVF] = tick & (&count_q);
  end

  // per flag: a new event wins over a clear in the same cycle
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_d[i] = set_v[i] | (flag_q[i] & ~(clr_we & wdata[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      alarm_q <= '0;
      flag_q  <= '0;
      en_q    <= '0;
    end else begin
      count_q <= count_d;
      alarm_q <= alarm_d;
      flag_q  <= flag_d;
      en_q    <= en_d;
    end
  end

  assign count = count_q;
  assign flags = flag_q;
  assign irq   = |(flag_q & en_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_core_pkg::*;
#(
  parameter int PRE_W      = 20,
  parameter int CNT_W      = 32,
  parameter int RST_RELOAD = 32767
) (
  input  logic                 bus_clk,
  input  logic                 rtc_clk,
  input  logic                 arst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [CNT_W-1:0]     wr_data,
  output logic                 wr_busy,
  output logic                 rtc_tick,
  output logic [CNT_W-1:0]     rtc_count,
  output logic [NUM_FLAGS-1:0] rtc_flags,
  output logic                 rtc_irq
);
  logic             bus_rst_s, rtc_rst_s;
  logic             ap_v;
  logic [SEL_W-1:0] ap_sel;
  logic [CNT_W-1:0] ap_data;
  logic             ap_count, ap_reload, ap_alarm, ap_clear, ap_enable;
  logic             tick_w;

  rtc_rst_sync #(.STAGES(2)) i_bus_rst (
    .clk(bus_clk), .arst_n(arst_n), .srst_n(bus_rst_s));
  rtc_rst_sync #(.STAGES(2)) i_rtc_rst (
    .clk(rtc_clk), .arst_n(arst_n), .srst_n(rtc_rst_s));

  rtc_wr_cdc #(.DW(CNT_W), .SW(SEL_W)) i_cdc (
    .bclk(bus_clk), .brst_n(bus_rst_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .busy(wr_busy), .rclk(rtc_clk), .rrst_n(rtc_rst_s),
    .apply(ap_v), .ap_sel(ap_sel), .ap_data(ap_data));

  assign ap_count  = ap_v & (ap_sel == SEL_COUNT);
  assign ap_reload = ap_v & (ap_sel == SEL_RELOAD);
  assign ap_alarm  = ap_v & (ap_sel == SEL_ALARM);
  assign ap_clear  = ap_v & (ap_sel == SEL_CLEAR);
  assign ap_enable = ap_v & (ap_sel == SEL_ENABLE);

  rtc_prescaler #(.PW(PRE_W), .RST_RELOAD(RST_RELOAD)) i_pre (
    .clk(rtc_clk), .rst_n(rtc_rst_s), .reload_we(ap_reload),
    .reload_val(ap_data[PRE_W-1:0]), .restart(ap_count | ap_reload),
    .tick(tick_w));

  rtc_timer #(.CW(CNT_W)) i_tmr (
    .clk(rtc_clk), .rst_n(rtc_rst_s), .tick(tick_w), .load_we(ap_count),
    .alarm_we(ap_alarm), .clr_we(ap_clear), .en_we(ap_enable),
    .wdata(ap_data), .count(rtc_count), .flags(rtc_flags), .irq(rtc_irq));

  assign rtc_tick = tick_w;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_core_pkg::*;
#(
  parameter int CW = 32
) (
  input logic                 rtc_clk,
  input logic                 bus_clk,
  input logic                 rrst_n,
  input logic                 brst_n,
  input logic                 tick,
  input logic                 load,
  input logic                 clr_we,
  input logic                 wr_en,
  input logic                 wr_busy,
  input logic [CW-1:0]        count,
  input logic [NUM_FLAGS-1:0] flags
);
  localparam logic [CW-1:0] ONE = CW'(1);

  AST_TICK_ADVANCES: assert property (@(posedge rtc_clk) disable iff (!rrst_n)
    (tick && !load) |=> (count == $past(count) + ONE)); // R3
  AST_COUNT_HOLDS: assert property (@(posedge rtc_clk) disable iff (!rrst_n)
    (!tick && !load) |=> $stable(count)); // R3
  AST_SECOND_SETS: assert property (@(posedge rtc_clk) disable iff (!rrst_n)
    tick |=> flags[FLAG_SEC]); // R5
  AST_WRAP_SETS_OVERFLOW: assert property (@(posedge rtc_clk) disable iff (!rrst_n)
    (tick && (&count)) |=> flags[FLAG_OVF]); // R7
  AST_FLAGS_STICKY: assert property (@(posedge rtc_clk) disable iff (!rrst_n)
    (|($past(flags) & ~flags)) |-> $past(clr_we)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge bus_clk) disable iff (!brst_n)
    (wr_en && !wr_busy) |=> wr_busy); // R10
endmodule

bind rtc_core rtc_core_chk #(.CW(CNT_W)) i_chk (
  .rtc_clk(rtc_clk), .bus_clk(bus_clk), .rrst_n(rtc_rst_s), .brst_n(bus_rst_s),
  .tick(tick_w), .load(ap_count), .clr_we(ap_clear), .wr_en(wr_en),
  .wr_busy(wr_busy), .count(rtc_count), .flags(rtc_flags));

// File: tb/test_rtc_core.sv
module test_rtc_core;
  import rtc_core_pkg::*;

  localparam int PRE_W = 20;
  localparam int CNT_W = 32;

  logic             bus_clk, rtc_clk, arst_n;
  logic             wr_en;
  logic [2:0]       wr_sel;
  logic [CNT_W-1:0] wr_data;
  logic             wr_busy, rtc_tick, rtc_irq;
  logic [CNT_W-1:0] rtc_count;
  logic [2:0]       rtc_flags;

  rtc_core #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RST_RELOAD(3)) i_rtc_core (
    .bus_clk(bus_clk), .rtc_clk(rtc_clk), .arst_n(arst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_busy(wr_busy), .rtc_tick(rtc_tick),
    .rtc_count(rtc_count), .rtc_flags(rtc_flags), .rtc_irq(rtc_irq));

  initial begin bus_clk = 0; forever #4 bus_clk = ~bus_clk; end
  initial begin rtc_clk = 0; #3; forever #20 rtc_clk = ~rtc_clk; end

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;

  typedef struct {
    logic [31:0] cnt;
    logic [2:0]  flg;
    int          per;
    string       req;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: every change of the counter pops one expected item
  logic [31:0] last_cnt;
  int          gap;
  item_t       it;
  always @(negedge rtc_clk) begin
    if (mon_on) begin
      gap++;
      if (rtc_count !== last_cnt) begin
        if (sb_q.size() > 0) begin
          it = sb_q.pop_front();
          chk(rtc_count === it.cnt, it.req, "count", rtc_count, it.cnt);
          chk(rtc_flags === it.flg, it.req, "flags", {29'd0, rtc_flags}, {29'd0, it.flg});
          if (it.per != 0) chk(gap == it.per, it.req, "tick period", gap, it.per);
        end
        last_cnt = rtc_count;
        gap = 0;
      end
    end
  end

  task automatic bus_wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge bus_clk);
    while (wr_busy) @(negedge bus_clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
    while (wr_busy) @(negedge bus_clk);
  endtask

  task automatic settle();
    @(negedge rtc_clk); #1;
  endtask

  task automatic push(input logic [31:0] c, input logic [2:0] f, input int p,
                      input string req);
    item_t n;
    n.cnt = c; n.flg = f; n.per = p; n.req = req;
    sb_q.push_back(n);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge rtc_clk);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 0; wr_en = 0; wr_sel = '0; wr_data = '0;
    #100 arst_n = 1;
    @(negedge rtc_clk);
    // R1: reset state
    chk(rtc_count === 0, "R1", "count", rtc_count, 0);
    chk(rtc_flags === 0, "R1", "flags", {29'd0, rtc_flags}, 0);
    chk(rtc_irq === 0, "R1", "irq", {31'd0, rtc_irq}, 0);
    chk(wr_busy === 0, "R1", "busy", {31'd0, wr_busy}, 0);
    last_cnt = rtc_count; gap = 0; mon_on = 1;

    // slow ticking gives a quiet window; clear everything (R8)
    bus_wr(SEL_RELOAD, 200);
    bus_wr(SEL_CLEAR, 7);
    settle();
    chk(rtc_flags === 0, "R8", "flags after full clear", {29'd0, rtc_flags}, 0);
    bus_wr(SEL_ALARM, 32'h105);
    // R2 R3 R4 R5 R6: reload 3, load 0x100, alarm at 0x105
    bus_wr(SEL_RELOAD, 3);
    bus_wr(SEL_COUNT, 32'h100);
    settle();
    for (int k = 1; k <= 7; k++)
      push(32'h100 + k, (k >= 5) ? 3'b011 : 3'b001, 4, "R2 R3 R4 R5 R6");
    drain();

    // R9: masking
    settle();
    chk(rtc_irq === 0, "R9", "irq all masked", {31'd0, rtc_irq}, 0);
    bus_wr(SEL_ENABLE, 3'b010);
    settle();
    chk(rtc_irq === 1, "R9", "irq alarm enabled", {31'd0, rtc_irq}, 1);
    bus_wr(SEL_ENABLE, 3'b100);
    settle();
    chk(rtc_irq === 0, "R9", "irq overflow only", {31'd0, rtc_irq}, 0);

    // R8: partial clear leaves the alarm flag
    bus_wr(SEL_RELOAD, 200);
    bus_wr(SEL_CLEAR, 3'b001);
    settle();
    chk(rtc_flags === 3'b010, "R8", "flags after partial clear", {29'd0, rtc_flags}, 32'h2);
    bus_wr(SEL_CLEAR, 7);
    settle();
    chk(rtc_flags === 0, "R8", "flags cleared", {29'd0, rtc_flags}, 0);

    // R10: second write while busy is dropped
    @(negedge bus_clk);
    wr_en = 1; wr_sel = SEL_COUNT; wr_data = 32'h500;
    @(negedge bus_clk);
    chk(wr_busy === 1, "R10", "busy after accept", {31'd0, wr_busy}, 1);
    wr_data = 32'h900;
    @(negedge bus_clk);
    wr_en = 0;
    while (wr_busy) @(negedge bus_clk);
    settle();
    chk(rtc_count === 32'h500, "R10", "count after ignored write", rtc_count, 32'h500);

    // R2: reload 0 ticks every cycle
    bus_wr(SEL_RELOAD, 0);
    bus_wr(SEL_COUNT, 32'h50);
    settle();
    for (int k = 1; k <= 4; k++) push(32'h50 + k, 3'b001, 1, "R2 R3");
    drain();

    // R7: wrap sets overflow
    bus_wr(SEL_RELOAD, 200);
    bus_wr(SEL_CLEAR, 7);
    bus_wr(SEL_RELOAD, 1);
    bus_wr(SEL_COUNT, 32'hFFFF_FFFD);
    settle();
    push(32'hFFFF_FFFE, 3'b001, 2, "R7 R4");
    push(32'hFFFF_FFFF, 3'b001, 2, "R7");
    push(32'h0000_0000, 3'b101, 2, "R7");
    push(32'h0000_0001, 3'b101, 2, "R7");
    drain();
    bus_wr(SEL_ENABLE, 3'b100);
    settle();
    chk(rtc_irq === 1, "R9", "irq overflow enabled", {31'd0, rtc_irq}, 1);

    // R2: only the low 20 bits of reload data count (period 3)
    bus_wr(SEL_RELOAD, 32'h0010_0002);
    bus_wr(SEL_COUNT, 32'h20);
    settle();
    for (int k = 1; k <= 3; k++) push(32'h20 + k, 3'b101, 3, "R2 reload field");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule